// File: doc/BRIEF.md
# Direct-mapped instruction cache with critical-word-first refill

This block sits between a processor's instruction fetch port and a pipelined memory read master. It is read-only and direct-mapped. Every line holds eight 32-bit words (32 bytes), so the low five bits of a byte address select a byte inside the line, and bits [4:2] select the word. The next `$clog2(LINES)` bits choose the line. All remaining upper bits form the tag. On a hit, the addressed word comes back one cycle after the request is accepted.

On a miss, the whole line is refilled with single-word reads, at most one per clock. The first read asks for the word that missed. The following reads step upward through the line and wrap around at the end. The stalled fetch is answered as soon as that first word arrives. New fetches are held off until the remaining words are stored and the line is marked valid. A flush pin invalidates every line at once.

Back-pressure works as follows. A fetch is taken on a cycle where `fetch_valid` and `fetch_ready` are both high. The address must be held until that cycle. The response has no ready: the fetch side must take `resp_valid`/`resp_data` when they appear. A memory read issues on a cycle where `mem_req_valid` and `mem_req_ready` are both high. While ready is low, the request and its address hold steady. Memory returns data in request order, one word per `mem_rvalid` pulse, and the cache always accepts it.

Top module: `icache_cwf`

## Requirements
- R1: After reset, `fetch_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0, and every line is invalid, so the first fetch of any address misses.
- R2: A hit answers with `resp_valid` high on the cycle after the accepting edge. `resp_data` is the word at address bits [4:2] of the line, and no memory read is issued.
- R3: A miss issues exactly eight memory reads. Each read's address is the fetch address with bits [4:0] replaced by the word number times 4, so bits [1:0] are 0.
- R4: The refill word numbers (address bits [4:2]) run c, c+1, … modulo 8, where c is bits [4:2] of the missed fetch address.
- R5: On a miss, `resp_valid` rises on the cycle after the first returned word is taken, and `resp_data` holds that word. `fetch_ready` stays low until the eighth word has been stored.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high on the next cycle and `mem_req_addr` does not change.
- R7: After a refill completes, a fetch of any of the line's eight words hits.
- R8: A fetch whose index matches a valid line but whose tag differs misses. It refills that line and evicts the old contents.
- R9: `flush` high makes every line invalid. `fetch_ready` is 0 while `flush` is high.
- R10: If `flush` is high at any time during a refill, the refill still completes and answers its fetch, but the line is left invalid.
- R11: Fetch address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all lines |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Cache can accept a fetch |
| fetch_addr | input | ADDR_W | Fetch byte address |
| resp_valid | output | 1 | Fetch response present (no back-pressure) |
| resp_data | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts a request |
| mem_req_addr | output | ADDR_W | Memory read byte address (word aligned) |
| mem_rvalid | input | 1 | Read data returning, in request order |
| mem_rdata | input | 32 | Read data word |

## Verification
The bench uses a small geometry: 8 lines and 12 address bits. It misses on every index with a different starting word each time, so all eight wrap orders are covered. Each refill is then followed by a sweep over all eight words, which separates correct line storage from a design that only got the critical word right. Refills run both with memory ready and returning data every cycle and with both signals stalled on alternate cycles. This shows whether beat counting and address holding follow the handshakes rather than elapsed cycles. Tag conflicts, a flush while idle, a flush during a refill and unaligned low address bits each target one specific way of wrongly reporting a hit.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 8;
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int OFF_W      = WSEL_W + 2;

  typedef enum logic {ST_IDLE, ST_FILL} ic_state_t;
endpackage

// File: rtl/icache_store.sv
module icache_store
  import icache_pkg::*;
#(
  parameter int LINES = 64,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              inval_en,
  input  logic [IDX_W-1:0]  inval_idx,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  set_tag
);
  logic [WORD_W-1:0] data_q [LINES*LINE_WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_data  = data_q[{rd_idx, rd_word}];

  always_ff @(posedge clk) begin
    if (wr_en) data_q[{wr_idx, wr_word}] <= wr_data;
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_valid
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        valid_q[g] <= 1'b0;
      else if (flush)                                    valid_q[g] <= 1'b0;
      else if (inval_en && inval_idx == IDX_W'(g))       valid_q[g] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g))           valid_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/icache_refill.sv
module icache_refill
  import icache_pkg::*;
#(
  parameter int ADDR_W = 31,
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BASE_W-1:0] line_base,
  input  logic [WSEL_W-1:0] crit_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rvalid,
  output logic              wr_en,
  output logic [WSEL_W-1:0] wr_word,
  output logic              first_beat,
  output logic              done
);
  logic              busy_q;
  logic [BASE_W-1:0] base_q;
  logic [WSEL_W-1:0] crit_q;
  logic [WSEL_W:0]   issued_q, recvd_q;
  logic [WSEL_W-1:0] issue_word;

  assign issue_word    = crit_q + issued_q[WSEL_W-1:0];
  assign mem_req_valid = busy_q && (issued_q < (WSEL_W+1)'(LINE_WORDS));
  assign mem_req_addr  = {base_q, issue_word, 2'b00};
  assign wr_en         = busy_q && mem_rvalid;
  assign wr_word       = crit_q + recvd_q[WSEL_W-1:0];
  assign first_beat    = wr_en && (recvd_q == '0);
  assign done          = wr_en && (recvd_q == (WSEL_W+1)'(LINE_WORDS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      base_q   <= '0;
      crit_q   <= '0;
      issued_q <= '0;
      recvd_q  <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      base_q   <= line_base;
      crit_q   <= crit_word;
      issued_q <= '0;
      recvd_q  <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) issued_q <= issued_q + 1'b1;
      if (wr_en) recvd_q <= recvd_q + 1'b1;
      if (done) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/icache_cwf.sv
module icache_cwf
  import icache_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int LINES  = 64,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              resp_valid,
  output logic [31:0]       resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  ic_state_t         state_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              poison_q;

  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  logic [WSEL_W-1:0] f_word;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid;
  logic [WORD_W-1:0] rd_data;
  logic              fire, hit, start;
  logic              wr_en, first_beat, done, set_en;
  logic [WSEL_W-1:0] wr_word;

  assign f_idx  = fetch_addr[OFF_W +: IDX_W];
  assign f_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
  assign f_word = fetch_addr[2 +: WSEL_W];

  assign fetch_ready = (state_q == ST_IDLE) && !flush;
  assign fire        = fetch_valid && fetch_ready;
  assign hit         = rd_valid && (rd_tag == f_tag);
  assign start       = fire && !hit;
  assign set_en      = done && !poison_q && !flush;

  icache_store #(.LINES(LINES), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_idx(f_idx), .rd_word(f_word),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(pend_idx_q), .wr_word(wr_word), .wr_data(mem_rdata),
    .inval_en(start), .inval_idx(f_idx),
    .set_en(set_en), .set_idx(pend_idx_q), .set_tag(pend_tag_q)
  );

  icache_refill #(.ADDR_W(ADDR_W)) refill_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .line_base(fetch_addr[ADDR_W-1:OFF_W]), .crit_word(f_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid),
    .wr_en(wr_en), .wr_word(wr_word), .first_beat(first_beat), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_idx_q <= '0;
      pend_tag_q <= '0;
      poison_q   <= 1'b0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= (fire && hit) || first_beat;
      if (first_beat)       resp_data <= mem_rdata;
      else if (fire && hit) resp_data <= rd_data;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q    <= ST_FILL;
          pend_idx_q <= f_idx;
          pend_tag_q <= f_tag;
          poison_q   <= 1'b0;
        end
        ST_FILL: begin
          if (flush) poison_q <= 1'b1;
          if (done)  state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icache_cwf_chk.sv
module icache_cwf_chk #(
  parameter int ADDR_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              resp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rvalid
);
  a_r5_no_fetch_while_filling: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !fetch_ready);

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r4_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=>
      (!mem_req_valid ||
       (mem_req_addr[4:2] == 3'($past(mem_req_addr[4:2]) + 3'd1) &&
        mem_req_addr[ADDR_W-1:5] == $past(mem_req_addr[ADDR_W-1:5]))));

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  a_r2_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> ($past(fetch_valid && fetch_ready) || $past(mem_rvalid)));

  a_r9_flush_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fetch_ready);
endmodule

bind icache_cwf icache_cwf_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .resp_valid(resp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid)
);

// File: tb/icache_cwf_tb_top.sv
module icache_cwf_tb_top;
  localparam int AW = 12;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic fetch_ready, resp_valid, mem_req_valid;
  logic [31:0] resp_data;
  logic [AW-1:0] mem_req_addr;
  logic mem_req_ready, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  icache_cwf #(.ADDR_W(AW), .LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit slow = 1'b0;
  int unsigned cyc = 0;
  int reqs = 0, beats = 0, hold_err = 0;
  logic [AW-1:0] req_log [64];
  logic [AW-1:0] q_addr [16];
  int q_wp = 0, q_rp = 0;
  logic prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [31:0] mword(input logic [AW-1:0] a);
    return ({20'd0, a} >> 2) * 32'h0100_0193 ^ 32'h5A5A_0000;
  endfunction

  assign mem_req_ready = slow ? cyc[0] : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_stall <= mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_req_addr;
    if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_err <= hold_err + 1;
    if (mem_rvalid) beats <= beats + 1;
    if (mem_req_valid && mem_req_ready) begin
      req_log[reqs % 64] <= mem_req_addr;
      reqs <= reqs + 1;
      q_addr[q_wp % 16] <= mem_req_addr;
      q_wp <= q_wp + 1;
    end
    if (q_rp != q_wp && (!slow || cyc[1])) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mword(q_addr[q_rp % 16]);
      q_rp <= q_rp + 1;
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a, input bit exp_miss, input string req);
    int r0, b0, lat;
    r0 = reqs;
    b0 = beats;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    while (!fetch_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    lat = 1;
    while (!resp_valid) begin @(negedge clk); lat++; end
    chk(resp_data == mword(a & ~12'd3), req, resp_data, mword(a & ~12'd3));
    if (exp_miss) begin
      chk(beats - b0 == 1, {req, " R5 early resp"}, beats - b0, 1);
      chk(!fetch_ready, {req, " R5 stall"}, fetch_ready, 0);
      while (!fetch_ready) @(negedge clk);
      @(negedge clk);
      chk(reqs - r0 == 8, {req, " R3 count"}, reqs - r0, 8);
      for (int k = 0; k < 8; k++) begin
        logic [AW-1:0] ea;
        ea = {a[AW-1:5], 3'(a[4:2] + 3'(k)), 2'b00};
        chk(req_log[(r0 + k) % 64] == ea, {req, " R4 order"}, req_log[(r0 + k) % 64], ea);
      end
    end else begin
      chk(lat == 1, {req, " R2 latency"}, lat, 1);
      chk(reqs == r0, {req, " R2 no mem"}, reqs - r0, 0);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    summary();
  end

  function automatic logic [AW-1:0] mk(input int t, input int i, input int w, input int b);
    return {4'(t), 3'(i), 3'(w), 2'(b)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R1 ready", fetch_ready, 1);
    chk(resp_valid == 1'b0, "R1 resp", resp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem", mem_req_valid, 0);

    // R1, R3, R4, R5, R7: miss each index with a distinct critical word, then sweep the line
    for (int i = 0; i < NL; i++) begin
      slow = i[0];
      fetch(mk(i + 3, i, (i * 3) % 8, 0), 1'b1, "R1/R5 miss");
      for (int w = 0; w < 8; w++) fetch(mk(i + 3, i, w, 0), 1'b0, "R7 hit");
    end
    // R11: low bits ignored
    fetch(mk(5, 2, 6, 3), 1'b0, "R11 hit");
    fetch(mk(5, 2, 1, 1), 1'b0, "R11 hit");

    // R8: conflicts evict
    slow = 1'b0;
    for (int i = 0; i < NL; i++) begin
      fetch(mk(i + 9, i, 7 - i, 0), 1'b1, "R8 conflict");
      fetch(mk(i + 9, i, i, 0), 1'b0, "R8 new hit");
    end
    fetch(mk(3, 0, 2, 0), 1'b1, "R8 old evicted");

    // R9: flush while idle
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(fetch_ready == 1'b0, "R9 ready during flush", fetch_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    fetch(mk(3, 0, 2, 0), 1'b1, "R9 miss after flush");
    fetch(mk(10, 1, 4, 0), 1'b1, "R9 miss after flush");

    // R10: flush during refill
    slow = 1'b1;
    fork
      fetch(mk(14, 5, 3, 0), 1'b1, "R10 fill");
      begin
        repeat (4) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
    join
    fetch(mk(14, 5, 0, 0), 1'b1, "R10 not kept");
    fetch(mk(14, 5, 6, 0), 1'b0, "R10 refilled hit");

    chk(hold_err == 0, "R6 hold while not ready", hold_err, 0);
    summary();
  end
endmodule